// File: doc/BRIEF.md
# Per-CPU Interrupt Interface with Split End-of-Interrupt

This block sits between an interrupt distributor and one processor. The distributor presents a level-sensitive pending vector together with an 8-bit priority for each of the interrupt IDs. The block picks the most urgent candidate and raises a single IRQ line toward the CPU when that candidate clears three gates: the interface enable, the priority mask, and the current running priority. Software talks to the block through simple single-cycle strobes. These strobes cover an acknowledge read, an end-of-interrupt write, a deactivate write, a priority mask write and a control write.

An acknowledge reads and changes state at once. It returns the winning ID and marks that interrupt active. It also pushes the interrupt onto a small stack of active interrupts whose priority has not been dropped. The top of that stack sets the running priority, so a more urgent interrupt can preempt one that is already being serviced. There are two end-of-interrupt modes. In combined mode one write drops the priority and retires the interrupt. In split mode the write only drops the priority, and a separate deactivate write retires the interrupt later.

Top module: `irqif_cpu`

## Requirements
- R1: After reset, irq_o is low, rpr_o reads 0xFF and ack_id_o reads the spurious ID 1023. The control register resets with both bits clear, and the priority mask resets to 0x00.
- R2: An acknowledge strobe returns on ack_id_o, one cycle later, the pending, non-active ID with the numerically lowest priority. On equal priority the lowest ID wins. The acknowledged ID becomes active.
- R3: An active interrupt is never returned by a further acknowledge, even while its pending line stays high. An acknowledge that finds no qualifying interrupt returns 1023 and changes no state.
- R4: An interrupt qualifies only when its priority is strictly below the priority mask (written through pmr_wr_i).
- R5: An interrupt qualifies only when its priority is strictly below the running priority, which allows nesting. When STACK_DEPTH interrupts are already on the stack, nothing qualifies.
- R6: rpr_o equals the priority of the most recently acknowledged interrupt whose priority has not been dropped. It reads 0xFF when no such interrupt exists.
- R7: In combined mode (control bit 1 clear), an end-of-interrupt write of the ID on top of the stack both drops the priority and deactivates the interrupt, so the interrupt can be acknowledged again while it is still pending.
- R8: In split mode (control bit 1 set), an end-of-interrupt write only drops the priority. The interrupt stays active and is not signalled again until a deactivate write names its ID.
- R9: An end-of-interrupt write whose ID is not on top of the stack leaves rpr_o unchanged and has no effect.
- R10: A deactivate write is ignored in combined mode. It is also ignored when the ID is still on the priority stack or is not active.
- R11: While the enable bit (control bit 0) is clear, irq_o stays low and an acknowledge returns 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pend_i | input | NUM_IRQ | Pending level per interrupt ID from the distributor |
| prio_i | input | NUM_IRQ*8 | Priority per ID, ID n in bits [8n+7:8n] |
| ctrl_wr_i | input | 1 | Control write strobe |
| ctrl_wdata_i | input | 2 | Bit 0 enable, bit 1 split mode |
| pmr_wr_i | input | 1 | Priority mask write strobe |
| pmr_wdata_i | input | 8 | New priority mask |
| ack_rd_i | input | 1 | Acknowledge read strobe |
| ack_id_o | output | 10 | Acknowledged ID, or 1023, valid the cycle after the strobe |
| eoi_wr_i | input | 1 | End-of-interrupt write strobe |
| eoi_id_i | input | 10 | ID written with end-of-interrupt |
| dir_wr_i | input | 1 | Deactivate write strobe |
| dir_id_i | input | 10 | ID written with deactivate |
| irq_o | output | 1 | Interrupt request to the CPU |
| rpr_o | output | 8 | Running priority |

## Verification
The hardest state to reach from the ports is a full priority stack. Reaching it takes a ladder of acknowledges, each one more urgent than the last. The bench raises the pending lines one at a time with falling priorities and acknowledges each before raising the next. It then raises a fifth, still more urgent line and confirms that the IRQ line stays low and that the acknowledge is spurious. The split-mode window also needs an exact order of strobes. This is the window in which an interrupt has had its priority dropped but has not yet been deactivated. The bench drives acknowledge, then end-of-interrupt, then deactivate, and confirms that the pending line is masked only inside that window. It also sends a deactivate too early and shows that it has no effect.

// File: rtl/irqif_pkg.sv
package irqif_pkg;
    localparam int ID_W   = 10;
    localparam int PRIO_W = 8;
    localparam logic [ID_W-1:0]   SPURIOUS_ID = 10'd1023;
    localparam logic [PRIO_W-1:0] IDLE_PRIO   = 8'hFF;

    typedef struct packed {
        logic split;
        logic en;
    } ctrl_t;
endpackage

// File: rtl/irqif_arbiter.sv
module irqif_arbiter
    import irqif_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0]        cand_i,
    input  logic [N*PRIO_W-1:0] prio_i,
    output logic                vld_o,
    output logic [ID_W-1:0]     id_o,
    output logic [PRIO_W-1:0]   prio_o
);
    logic [PRIO_W-1:0] prio_a [N];

    for (genvar g = 0; g < N; g++) begin : g_unpack
        assign prio_a[g] = prio_i[g*PRIO_W +: PRIO_W];
    end

    // Linear scan; strict compare keeps the lowest ID on ties.
    always_comb begin
        vld_o  = 1'b0;
        id_o   = '0;
        prio_o = IDLE_PRIO;
        for (int i = 0; i < N; i++) begin
            if (cand_i[i] && (!vld_o || prio_a[i] < prio_o)) begin
                vld_o  = 1'b1;
                id_o   = ID_W'(i);
                prio_o = prio_a[i];
            end
        end
    end
endmodule

// File: rtl/irqif_prio_stack.sv
module irqif_prio_stack
    import irqif_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              push_i,
    input  logic [ID_W-1:0]   push_id_i,
    input  logic [PRIO_W-1:0] push_prio_i,
    input  logic              pop_i,
    input  logic [ID_W-1:0]   query_id_i,
    output logic              query_hit_o,
    output logic              top_vld_o,
    output logic [ID_W-1:0]   top_id_o,
    output logic [PRIO_W-1:0] top_prio_o,
    output logic              full_o
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][ID_W-1:0]   ids;
        logic [DEPTH-1:0][PRIO_W-1:0] prios;
        logic [CW-1:0]                cnt;
    } stk_t;

    stk_t st_d, st_q;
    logic [CW-1:0] top_idx, wr_idx;

    always_comb begin
        top_idx     = st_q.cnt - CW'(1);
        top_vld_o   = (st_q.cnt != '0);
        full_o      = (st_q.cnt == CW'(DEPTH));
        top_id_o    = '0;
        top_prio_o  = IDLE_PRIO;
        query_hit_o = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (top_vld_o && CW'(i) == top_idx) begin
                top_id_o   = st_q.ids[i];
                top_prio_o = st_q.prios[i];
            end
            if (CW'(i) < st_q.cnt && st_q.ids[i] == query_id_i) begin
                query_hit_o = 1'b1;
            end
        end
    end

    always_comb begin
        st_d   = st_q;
        wr_idx = (pop_i && top_vld_o) ? top_idx : st_q.cnt;
        if (pop_i && top_vld_o) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
        if (push_i && (!full_o || pop_i)) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) == wr_idx) begin
                    st_d.ids[i]   = push_id_i;
                    st_d.prios[i] = push_prio_i;
                end
            end
            st_d.cnt = st_d.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/irqif_cpu.sv
module irqif_cpu
    import irqif_pkg::*;
#(
    parameter int NUM_IRQ     = 32,
    parameter int STACK_DEPTH = 4
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [NUM_IRQ-1:0]        pend_i,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
    input  logic                      ctrl_wr_i,
    input  logic [1:0]                ctrl_wdata_i,
    input  logic                      pmr_wr_i,
    input  logic [PRIO_W-1:0]         pmr_wdata_i,
    input  logic                      ack_rd_i,
    output logic [ID_W-1:0]           ack_id_o,
    input  logic                      eoi_wr_i,
    input  logic [ID_W-1:0]           eoi_id_i,
    input  logic                      dir_wr_i,
    input  logic [ID_W-1:0]           dir_id_i,
    output logic                      irq_o,
    output logic [PRIO_W-1:0]         rpr_o
);
    localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    typedef struct packed {
        logic [NUM_IRQ-1:0] active;
        logic [ID_W-1:0]    ack_id;
        ctrl_t              ctrl;
        logic [PRIO_W-1:0]  pmr;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_IRQ-1:0] cand;
    logic               best_vld;
    logic [ID_W-1:0]    best_id;
    logic [PRIO_W-1:0]  best_prio;
    logic               top_vld, stk_full, in_stack;
    logic [ID_W-1:0]    top_id;
    logic [PRIO_W-1:0]  top_prio;
    logic               qualify, ack_take, eoi_hit, dir_hit;
    logic               if_en;

    assign cand  = pend_i & ~st_q.active;
    assign if_en = st_q.ctrl.en;

    irqif_arbiter #(.N(NUM_IRQ)) u_arb (
        .cand_i (cand),
        .prio_i (prio_i),
        .vld_o  (best_vld),
        .id_o   (best_id),
        .prio_o (best_prio)
    );

    irqif_prio_stack #(.DEPTH(STACK_DEPTH)) u_stk (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .push_i      (ack_take),
        .push_id_i   (best_id),
        .push_prio_i (best_prio),
        .pop_i       (eoi_hit),
        .query_id_i  (dir_id_i),
        .query_hit_o (in_stack),
        .top_vld_o   (top_vld),
        .top_id_o    (top_id),
        .top_prio_o  (top_prio),
        .full_o      (stk_full)
    );

    always_comb begin
        rpr_o    = top_vld ? top_prio : IDLE_PRIO;
        qualify  = st_q.ctrl.en && best_vld && !stk_full
                   && (best_prio < st_q.pmr) && (best_prio < rpr_o);
        irq_o    = qualify;
        ack_id_o = st_q.ack_id;
        ack_take = ack_rd_i && qualify;
        eoi_hit  = eoi_wr_i && top_vld && (eoi_id_i == top_id);
        dir_hit  = dir_wr_i && st_q.ctrl.split
                   && (dir_id_i < ID_W'(NUM_IRQ))
                   && st_q.active[dir_id_i[IDX_W-1:0]]
                   && !in_stack;
    end

    always_comb begin
        st_d = st_q;
        if (ctrl_wr_i) begin
            st_d.ctrl.en    = ctrl_wdata_i[0];
            st_d.ctrl.split = ctrl_wdata_i[1];
        end
        if (pmr_wr_i) begin
            st_d.pmr = pmr_wdata_i;
        end
        if (ack_rd_i) begin
            st_d.ack_id = ack_take ? best_id : SPURIOUS_ID;
        end
        if (eoi_hit && !st_q.ctrl.split) begin
            st_d.active[eoi_id_i[IDX_W-1:0]] = 1'b0;
        end
        if (dir_hit) begin
            st_d.active[dir_id_i[IDX_W-1:0]] = 1'b0;
        end
        if (ack_take) begin
            st_d.active[best_id[IDX_W-1:0]] = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q        <= '0;
            st_q.ack_id <= SPURIOUS_ID;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/irqif_cpu_chk.sv
module irqif_cpu_chk
    import irqif_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input logic              ack_rd,
    input logic [ID_W-1:0]   ack_id,
    input logic              eoi_wr,
    input logic [PRIO_W-1:0] rpr,
    input logic              enable
);
    p_irq_needs_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> enable);

    p_ack_off_spur_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !enable) |=> (ack_id == SPURIOUS_ID));

    p_ack_real_id_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && irq) |=> (ack_id != SPURIOUS_ID));

    p_ack_none_spur_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !irq) |=> (ack_id == SPURIOUS_ID));

    p_ack_raises_rpr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && irq && !eoi_wr) |=> (rpr < $past(rpr)));

    p_eoi_lowers_rpr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && !ack_rd) |=> (rpr >= $past(rpr)));

    p_rpr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_rd && !eoi_wr) |=> $stable(rpr));
endmodule

bind irqif_cpu irqif_cpu_chk u_chk (
    .clk    (clk_i),
    .rst_n  (rst_ni),
    .irq    (irq_o),
    .ack_rd (ack_rd_i),
    .ack_id (ack_id_o),
    .eoi_wr (eoi_wr_i),
    .rpr    (rpr_o),
    .enable (if_en)
);

// File: tb/irqif_cpu_test.sv
module irqif_cpu_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;
    localparam logic [9:0] SPUR = 10'd1023;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  pend;
    logic [N*8-1:0] prio;
    logic          ctrl_wr, pmr_wr, ack_rd, eoi_wr, dir_wr;
    logic [1:0]    ctrl_wdata;
    logic [7:0]    pmr_wdata;
    logic [9:0]    eoi_id, dir_id, ack_id;
    logic          irq;
    logic [7:0]    rpr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqif_cpu uut (
        .clk_i(clk), .rst_ni(rst_n), .pend_i(pend), .prio_i(prio),
        .ctrl_wr_i(ctrl_wr), .ctrl_wdata_i(ctrl_wdata),
        .pmr_wr_i(pmr_wr), .pmr_wdata_i(pmr_wdata),
        .ack_rd_i(ack_rd), .ack_id_o(ack_id),
        .eoi_wr_i(eoi_wr), .eoi_id_i(eoi_id),
        .dir_wr_i(dir_wr), .dir_id_i(dir_id),
        .irq_o(irq), .rpr_o(rpr)
    );

    task automatic check(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0; pend = '0; prio = '1;
        ctrl_wr = 0; pmr_wr = 0; ack_rd = 0; eoi_wr = 0; dir_wr = 0;
        ctrl_wdata = 0; pmr_wdata = 0; eoi_id = 0; dir_id = 0;
        repeat (2) tick();
        rst_n = 1;
        tick();
    endtask

    task automatic set_ctrl(bit en, bit split);
        ctrl_wr = 1; ctrl_wdata = {split, en}; tick(); ctrl_wr = 0; tick();
    endtask

    task automatic set_pmr(logic [7:0] v);
        pmr_wr = 1; pmr_wdata = v; tick(); pmr_wr = 0; tick();
    endtask

    task automatic raise(int id, logic [7:0] p);
        prio[id*8 +: 8] = p; pend[id] = 1'b1; tick();
    endtask

    task automatic do_ack(output int id);
        ack_rd = 1; tick(); ack_rd = 0; id = int'(ack_id);
    endtask

    task automatic do_eoi(int id);
        eoi_wr = 1; eoi_id = 10'(id); tick(); eoi_wr = 0; tick();
    endtask

    task automatic do_dir(int id);
        dir_wr = 1; dir_id = 10'(id); tick(); dir_wr = 0; tick();
    endtask

    task automatic setup(bit split);
        do_reset(); set_ctrl(1'b1, split); set_pmr(8'hF0);
    endtask

    task automatic t_reset();
        int id;
        do_reset();
        check("R1 irq after reset", irq, 0);
        check("R1 rpr after reset", rpr, 8'hFF);
        check("R1 ack_id after reset", ack_id, SPUR);
        raise(2, 8'h10);
        check("R1 irq low with pmr 0 and enable 0", irq, 0);
        do_ack(id);
        check("R1 ack spurious after reset", id, SPUR);
    endtask

    task automatic t_pick();
        int id;
        setup(0);
        raise(12, 8'h30); raise(9, 8'h20); raise(3, 8'h20);
        check("R2 irq raised", irq, 1);
        do_ack(id);
        check("R2 tie goes to lowest id", id, 3);
        check("R6 rpr after ack", rpr, 8'h20);
        do_eoi(3);
        pend[3] = 0; tick();
        do_ack(id);
        check("R2 next best", id, 9);
        do_ack(id);
        check("R3 nothing more urgent than 0x20", id, SPUR);
        check("R3 rpr unchanged by spurious ack", rpr, 8'h20);
    endtask

    task automatic t_no_reack();
        int id;
        setup(0);
        raise(5, 8'h40);
        do_ack(id);
        check("R2 single ack", id, 5);
        check("R3 irq low while active and pending", irq, 0);
        do_ack(id);
        check("R3 active not returned", id, SPUR);
    endtask

    task automatic t_mask();
        int id;
        setup(0);
        set_pmr(8'h50);
        raise(8, 8'h50);
        check("R4 equal to mask blocked", irq, 0);
        do_ack(id);
        check("R4 ack spurious at mask", id, SPUR);
        set_pmr(8'h51);
        check("R4 below mask signalled", irq, 1);
        do_ack(id);
        check("R4 ack after mask raised", id, 8);
    endtask

    task automatic t_preempt();
        int id;
        setup(0);
        raise(7, 8'h80);
        do_ack(id);
        check("R5 first ack", id, 7);
        raise(2, 8'h80);
        check("R5 equal priority does not preempt", irq, 0);
        raise(4, 8'h40);
        check("R5 more urgent preempts", irq, 1);
        do_ack(id);
        check("R5 nested ack", id, 4);
        check("R6 rpr nested", rpr, 8'h40);
        do_eoi(4);
        check("R6 rpr back to outer", rpr, 8'h80);
        do_eoi(7);
        check("R6 rpr idle", rpr, 8'hFF);
    endtask

    task automatic t_full();
        int id;
        setup(0);
        for (int k = 0; k < 4; k++) begin
            raise(10 + k, 8'(8'h50 - 8'h10 * k));
            do_ack(id);
            check("R5 ladder ack", id, 10 + k);
        end
        check("R6 rpr at top of ladder", rpr, 8'h20);
        raise(14, 8'h10);
        check("R5 full stack blocks irq", irq, 0);
        do_ack(id);
        check("R5 full stack ack spurious", id, SPUR);
        do_eoi(13);
        check("R5 room again", irq, 1);
    endtask

    task automatic t_combined();
        int id;
        setup(0);
        raise(6, 8'h60);
        do_ack(id);
        do_eoi(6);
        check("R7 rpr idle after eoi", rpr, 8'hFF);
        check("R7 deactivated so irq again", irq, 1);
        do_ack(id);
        check("R7 reacknowledge", id, 6);
        do_dir(6);
        check("R10 dir ignored in combined mode", rpr, 8'h60);
        do_ack(id);
        check("R10 still active after ignored dir", id, SPUR);
    endtask

    task automatic t_split();
        int id;
        setup(1);
        raise(6, 8'h60);
        do_ack(id);
        check("R8 split ack", id, 6);
        do_dir(6);
        do_eoi(6);
        check("R8 rpr dropped", rpr, 8'hFF);
        check("R10 early dir ignored, still active", irq, 0);
        do_ack(id);
        check("R8 no reack before dir", id, SPUR);
        do_dir(6);
        check("R8 dir retires", irq, 1);
        do_ack(id);
        check("R8 reack after dir", id, 6);
    endtask

    task automatic t_bad_eoi();
        int id;
        setup(0);
        raise(6, 8'h60);
        do_ack(id);
        do_eoi(0);
        check("R9 eoi of wrong id keeps rpr", rpr, 8'h60);
        do_eoi(6);
        check("R9 matching eoi drops", rpr, 8'hFF);
    endtask

    task automatic t_disable();
        int id;
        setup(0);
        set_ctrl(1'b0, 1'b0);
        raise(1, 8'h10);
        check("R11 irq low when disabled", irq, 0);
        do_ack(id);
        check("R11 ack spurious when disabled", id, SPUR);
        set_ctrl(1'b1, 1'b0);
        check("R11 irq after enable", irq, 1);
    endtask

    initial begin
        t_reset();
        t_pick();
        t_no_reack();
        t_mask();
        t_preempt();
        t_full();
        t_combined();
        t_split();
        t_bad_eoi();
        t_disable();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule